// File: doc/BRIEF.md
# Multi-Line Access Sequencer with Event Statistics

This block takes one memory access at a time, described by a start address, a byte count, a load/store flag and an address-space identifier. It walks the access line by line. Each line is presented to an external tag directory as a lookup, one lookup per clock cycle. The block collects the hit answer for every line and then reports a single result: the per-line hit bits, the number of lines visited, the combined hit flag and a truncation flag. A one-cycle `done` pulse marks that result.

Alongside the walker sit event counters that record one outcome per completed access, not one per line. The outcome is split by access kind (load or store) and by combined hit or miss. Software-visible sums are derived from those four counters. Two command inputs are also counted: a statistics clear, which empties the four outcome counters, and a flush notification.

The directory answers through `lk_hit` in the same cycle that `lk_valid` is high. It is expected to mark a line modified when a write lookup hits.

Top module: `span_access_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `lk_valid` are 0, and every counter output reads 0.
- R2: The first lookup appears the cycle after a request is accepted and uses the start address unchanged. Each later lookup follows in the very next cycle, at the previous lookup address with its low log2(LINE_BYTES) bits cleared plus LINE_BYTES.
- R3: The number of lookups equals the number of lines from the line holding the start address up to the line holding byte address+size-1. This count is never below one, and a size of 0 gives exactly one lookup.
- R4: In the result, bit i of `res_hit_vec` holds the hit answer of lookup i (lookup 0 in bit 0), and bits at or above `res_lines` are 0. `res_all_hit` is the AND of the used bits.
- R5: Every lookup of a request carries `lk_write` equal to the request's store flag and `lk_asid` equal to its identifier.
- R6: `req_ready` is 0 from acceptance until the cycle in which `done` pulses, and it is 1 in that cycle. `done` is high for exactly one cycle, the cycle after the last lookup.
- R7: At each completion exactly one of the four outcome counters increases by one. The counter is chosen by store flag and combined hit: load hit, load miss, store hit or store miss.
- R8: `cnt_ld_acc` = load hits + load misses, `cnt_st_acc` = store hits + store misses, and the three totals are the sums over both kinds.
- R9: A `cmd_stats_clr` cycle zeroes the four outcome counters and raises `cnt_clear` by one. A `cmd_flush` cycle raises `cnt_flush` by one and leaves the other counters unchanged.
- R10: When a clear falls in the last-lookup cycle of a request, the counters afterwards read 0 except the one selected by that request, which reads 1.
- R11: A request spanning more than MAX_LINES lines gets exactly MAX_LINES lookups and `res_trunc` = 1. Otherwise `res_trunc` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SIZE_W | Byte count (0 treated as one line) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_asid | input | ASID_W | Address-space identifier |
| lk_valid | output | 1 | Lookup presented to directory |
| lk_addr | output | ADDR_W | Lookup address |
| lk_write | output | 1 | Lookup is a write (marks line modified on hit) |
| lk_asid | output | ASID_W | Lookup identifier |
| lk_hit | input | 1 | Directory answer for the current lookup |
| done | output | 1 | One-cycle completion pulse |
| res_all_hit | output | 1 | AND of all line hits |
| res_lines | output | LCNT_W | Lines looked up |
| res_hit_vec | output | MAX_LINES | Per-line hit bits, lookup 0 in bit 0 |
| res_trunc | output | 1 | Request exceeded MAX_LINES lines |
| cmd_flush | input | 1 | Flush event to count |
| cmd_stats_clr | input | 1 | Clear outcome counters |
| cnt_ld_hit | output | CNT_W | Load hit count |
| cnt_ld_miss | output | CNT_W | Load miss count |
| cnt_st_hit | output | CNT_W | Store hit count |
| cnt_st_miss | output | CNT_W | Store miss count |
| cnt_ld_acc | output | CNT_W | Load accesses |
| cnt_st_acc | output | CNT_W | Store accesses |
| cnt_tot_hit | output | CNT_W | Hits of both kinds |
| cnt_tot_miss | output | CNT_W | Misses of both kinds |
| cnt_tot_acc | output | CNT_W | Accesses of both kinds |
| cnt_flush | output | CNT_W | Flush events |
| cnt_clear | output | CNT_W | Statistics clears |

## Verification
The statistics clear and the completion of a request can land on the same clock edge. In that case the counter update has to take both into account rather than let one of them win. The bench provokes this by raising `cmd_stats_clr` in exactly the cycle it sees the last expected lookup on the directory port, both in a directed case and at random points among randomized requests. It then compares all counters against a model that clears first and then counts the finishing request, so the selected counter must read one and the others zero.

// File: rtl/span_seq_pkg.sv
package span_seq_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;

  // Outcome slot = {store, all_hit}: 0 load miss, 1 load hit, 2 store miss, 3 store hit
  localparam int unsigned OUTCOME_SLOTS = 4;

  typedef logic [1:0] outcome_idx_t;

endpackage

// File: rtl/span_evt_ctr.sv
module span_evt_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  // Clear and increment in one cycle: clear first, then count.
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= inc ? W'(1) : '0;
    else if (inc) q <= q + W'(1);
  end

endmodule

// File: rtl/span_walker.sv
module span_walker
  import span_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SIZE_W     = 16,
  parameter int unsigned ASID_W     = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAX_LINES  = 8,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LCNT_W    = $clog2(MAX_LINES + 1),
  localparam int unsigned XA_W      = ADDR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_store,
  input  logic [ASID_W-1:0]    req_asid,
  output logic                 lk_valid,
  output logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_write,
  output logic [ASID_W-1:0]    lk_asid,
  input  logic                 lk_hit,
  output logic                 done,
  output logic                 res_all_hit,
  output logic [LCNT_W-1:0]    res_lines,
  output logic [MAX_LINES-1:0] res_hit_vec,
  output logic                 res_trunc,
  output logic                 fin,
  output logic                 fin_store,
  output logic                 fin_hit
);

  walk_state_e          state_q;
  logic [XA_W-1:0]      cur_q;
  logic [XA_W-1:0]      end_q;
  logic                 store_q;
  logic [ASID_W-1:0]    asid_q;
  logic [LCNT_W-1:0]    cnt_q;
  logic [MAX_LINES-1:0] vec_q;
  logic                 all_q;
  logic                 lkv_q;

  logic [XA_W-1:0]      line_base;
  logic [XA_W-1:0]      nxt_addr;
  logic                 more;
  logic                 at_cap;
  logic                 last;
  logic [MAX_LINES-1:0] vec_upd;

  // Extended width keeps the end-of-span compare exact at the top of the space.
  always_comb begin
    line_base = {cur_q[XA_W-1:OFF_W], {OFF_W{1'b0}}};
    nxt_addr  = line_base + XA_W'(LINE_BYTES);
    more      = nxt_addr < end_q;
    at_cap    = (cnt_q == LCNT_W'(MAX_LINES - 1));
    last      = lkv_q && (!more || at_cap);
    vec_upd   = vec_q | (MAX_LINES'(lk_hit) << cnt_q);
  end

  assign req_ready = (state_q == WALK_IDLE);
  assign lk_valid  = lkv_q;
  assign lk_addr   = cur_q[ADDR_W-1:0];
  assign lk_write  = store_q;
  assign lk_asid   = asid_q;
  assign fin       = last;
  assign fin_store = store_q;
  assign fin_hit   = all_q & lk_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WALK_IDLE;
      cur_q       <= '0;
      end_q       <= '0;
      store_q     <= 1'b0;
      asid_q      <= '0;
      cnt_q       <= '0;
      vec_q       <= '0;
      all_q       <= 1'b1;
      lkv_q       <= 1'b0;
      done        <= 1'b0;
      res_all_hit <= 1'b0;
      res_lines   <= '0;
      res_hit_vec <= '0;
      res_trunc   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (req_valid) begin
            cur_q   <= {1'b0, req_addr};
            end_q   <= {1'b0, req_addr} + XA_W'(req_size);
            store_q <= req_store;
            asid_q  <= req_asid;
            cnt_q   <= '0;
            vec_q   <= '0;
            all_q   <= 1'b1;
            lkv_q   <= 1'b1;
            state_q <= WALK_BUSY;
          end
        end
        WALK_BUSY: begin
          vec_q <= vec_upd;
          all_q <= all_q & lk_hit;
          cnt_q <= cnt_q + LCNT_W'(1);
          if (last) begin
            lkv_q       <= 1'b0;
            state_q     <= WALK_IDLE;
            done        <= 1'b1;
            res_hit_vec <= vec_upd;
            res_all_hit <= all_q & lk_hit;
            res_lines   <= cnt_q + LCNT_W'(1);
            res_trunc   <= more;
          end else begin
            cur_q <= nxt_addr;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  // R6: no new request is offered while lookups are outstanding
  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> !req_ready);

  // R6: completion pulse lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: back-to-back lookups advance to the start of the following line
  p_line_step_r2: assert property (@(posedge clk) disable iff (rst)
    lkv_q && $past(lkv_q) |->
      cur_q == {$past(cur_q[XA_W-1:OFF_W]) + 1'b1, {OFF_W{1'b0}}});

  // R5: lookup kind and identifier stay fixed within one request
  p_kind_stable_r5: assert property (@(posedge clk) disable iff (rst)
    lk_valid && $past(lk_valid) |-> $stable(lk_write) && $stable(lk_asid));

  // R11: a truncated result always reports the full cap of lines
  p_trunc_cap_r11: assert property (@(posedge clk) disable iff (rst)
    done && res_trunc |-> res_lines == LCNT_W'(MAX_LINES));

  // R4: hit bits beyond the reported line count are clear
  p_vec_tail_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_hit_vec >> res_lines) == '0);

endmodule

// File: rtl/span_stats.sv
module span_stats
  import span_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin,
  input  logic             fin_store,
  input  logic             fin_hit,
  input  logic             cmd_flush,
  input  logic             cmd_stats_clr,
  output logic [CNT_W-1:0] cnt_ld_hit,
  output logic [CNT_W-1:0] cnt_ld_miss,
  output logic [CNT_W-1:0] cnt_st_hit,
  output logic [CNT_W-1:0] cnt_st_miss,
  output logic [CNT_W-1:0] cnt_ld_acc,
  output logic [CNT_W-1:0] cnt_st_acc,
  output logic [CNT_W-1:0] cnt_tot_hit,
  output logic [CNT_W-1:0] cnt_tot_miss,
  output logic [CNT_W-1:0] cnt_tot_acc,
  output logic [CNT_W-1:0] cnt_flush,
  output logic [CNT_W-1:0] cnt_clear
);

  outcome_idx_t   slot;
  logic [CNT_W-1:0] slot_q [OUTCOME_SLOTS];

  assign slot = {fin_store, fin_hit};

  for (genvar g = 0; g < OUTCOME_SLOTS; g++) begin : g_outcome
    span_evt_ctr #(.W(CNT_W)) u_ctr (
      .clk (clk),
      .rst (rst),
      .clr (cmd_stats_clr),
      .inc (fin && (slot == outcome_idx_t'(g))),
      .q   (slot_q[g])
    );
  end

  span_evt_ctr #(.W(CNT_W)) u_flush_ctr (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .inc (cmd_flush),
    .q   (cnt_flush)
  );

  span_evt_ctr #(.W(CNT_W)) u_clear_ctr (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .inc (cmd_stats_clr),
    .q   (cnt_clear)
  );

  assign cnt_ld_miss  = slot_q[0];
  assign cnt_ld_hit   = slot_q[1];
  assign cnt_st_miss  = slot_q[2];
  assign cnt_st_hit   = slot_q[3];
  assign cnt_ld_acc   = cnt_ld_hit + cnt_ld_miss;
  assign cnt_st_acc   = cnt_st_hit + cnt_st_miss;
  assign cnt_tot_hit  = cnt_ld_hit + cnt_st_hit;
  assign cnt_tot_miss = cnt_ld_miss + cnt_st_miss;
  assign cnt_tot_acc  = cnt_ld_acc + cnt_st_acc;

  // R7: a completion without a clear adds exactly one event in total
  p_one_event_r7: assert property (@(posedge clk) disable iff (rst)
    fin && !cmd_stats_clr |=> cnt_tot_acc == $past(cnt_tot_acc) + CNT_W'(1));

  // R7: without completion or clear the outcome counters hold
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fin && !cmd_stats_clr |=> $stable(cnt_tot_acc));

  // R9: a clear alone empties every outcome counter
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_stats_clr && !fin |=> cnt_tot_acc == '0);

  // R10: clear with completion leaves exactly one event
  p_clear_finish_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_stats_clr && fin |=> cnt_tot_acc == CNT_W'(1));

  // R9: each flush command is counted once
  p_flush_count_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_flush |=> cnt_flush == $past(cnt_flush) + CNT_W'(1));

endmodule

// File: rtl/span_access_seq.sv
module span_access_seq
  import span_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SIZE_W     = 16,
  parameter int unsigned ASID_W     = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAX_LINES  = 8,
  parameter int unsigned CNT_W      = 32,
  localparam int unsigned LCNT_W    = $clog2(MAX_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_store,
  input  logic [ASID_W-1:0]    req_asid,
  output logic                 lk_valid,
  output logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_write,
  output logic [ASID_W-1:0]    lk_asid,
  input  logic                 lk_hit,
  output logic                 done,
  output logic                 res_all_hit,
  output logic [LCNT_W-1:0]    res_lines,
  output logic [MAX_LINES-1:0] res_hit_vec,
  output logic                 res_trunc,
  input  logic                 cmd_flush,
  input  logic                 cmd_stats_clr,
  output logic [CNT_W-1:0]     cnt_ld_hit,
  output logic [CNT_W-1:0]     cnt_ld_miss,
  output logic [CNT_W-1:0]     cnt_st_hit,
  output logic [CNT_W-1:0]     cnt_st_miss,
  output logic [CNT_W-1:0]     cnt_ld_acc,
  output logic [CNT_W-1:0]     cnt_st_acc,
  output logic [CNT_W-1:0]     cnt_tot_hit,
  output logic [CNT_W-1:0]     cnt_tot_miss,
  output logic [CNT_W-1:0]     cnt_tot_acc,
  output logic [CNT_W-1:0]     cnt_flush,
  output logic [CNT_W-1:0]     cnt_clear
);

  logic fin;
  logic fin_store;
  logic fin_hit;

  span_walker #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .ASID_W     (ASID_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_LINES  (MAX_LINES)
  ) u_walker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_store   (req_store),
    .req_asid    (req_asid),
    .lk_valid    (lk_valid),
    .lk_addr     (lk_addr),
    .lk_write    (lk_write),
    .lk_asid     (lk_asid),
    .lk_hit      (lk_hit),
    .done        (done),
    .res_all_hit (res_all_hit),
    .res_lines   (res_lines),
    .res_hit_vec (res_hit_vec),
    .res_trunc   (res_trunc),
    .fin         (fin),
    .fin_store   (fin_store),
    .fin_hit     (fin_hit)
  );

  span_stats #(.CNT_W(CNT_W)) u_stats (
    .clk           (clk),
    .rst           (rst),
    .fin           (fin),
    .fin_store     (fin_store),
    .fin_hit       (fin_hit),
    .cmd_flush     (cmd_flush),
    .cmd_stats_clr (cmd_stats_clr),
    .cnt_ld_hit    (cnt_ld_hit),
    .cnt_ld_miss   (cnt_ld_miss),
    .cnt_st_hit    (cnt_st_hit),
    .cnt_st_miss   (cnt_st_miss),
    .cnt_ld_acc    (cnt_ld_acc),
    .cnt_st_acc    (cnt_st_acc),
    .cnt_tot_hit   (cnt_tot_hit),
    .cnt_tot_miss  (cnt_tot_miss),
    .cnt_tot_acc   (cnt_tot_acc),
    .cnt_flush     (cnt_flush),
    .cnt_clear     (cnt_clear)
  );

  // R1: the counters and the sequencer leave reset together, so an idle
  // sequencer never shows a completion pulse
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> req_ready && !lk_valid && !done);

endmodule

// File: tb/span_access_seq_tb_top.sv
module span_access_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int SIZE_W     = 16;
  localparam int ASID_W     = 8;
  localparam int LINE_BYTES = 64;
  localparam int OFF        = 6;
  localparam int MAX_LINES  = 8;
  localparam int CNT_W      = 32;
  localparam int LCNT_W     = $clog2(MAX_LINES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic req_store = 1'b0;
  logic [ASID_W-1:0] req_asid = '0;
  logic lk_valid;
  logic [ADDR_W-1:0] lk_addr;
  logic lk_write;
  logic [ASID_W-1:0] lk_asid;
  logic lk_hit;
  logic done, res_all_hit, res_trunc;
  logic [LCNT_W-1:0] res_lines;
  logic [MAX_LINES-1:0] res_hit_vec;
  logic cmd_flush = 1'b0;
  logic cmd_stats_clr = 1'b0;
  logic [CNT_W-1:0] c_lh, c_lm, c_sh, c_sm, c_la, c_sa, c_th, c_tm, c_ta, c_fl, c_cl;
  logic [7:0] hit_pat = 8'h00;

  span_access_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_store(req_store), .req_asid(req_asid),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .done(done), .res_all_hit(res_all_hit), .res_lines(res_lines),
    .res_hit_vec(res_hit_vec), .res_trunc(res_trunc), .cmd_flush(cmd_flush),
    .cmd_stats_clr(cmd_stats_clr), .cnt_ld_hit(c_lh), .cnt_ld_miss(c_lm),
    .cnt_st_hit(c_sh), .cnt_st_miss(c_sm), .cnt_ld_acc(c_la), .cnt_st_acc(c_sa),
    .cnt_tot_hit(c_th), .cnt_tot_miss(c_tm), .cnt_tot_acc(c_ta),
    .cnt_flush(c_fl), .cnt_clear(c_cl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Directory model: hit decided by line number modulo 8
  assign lk_hit = hit_pat[lk_addr[OFF+2:OFF]];

  int checks = 0;
  int fails  = 0;
  longint exp_slot [4];   // 0 load miss, 1 load hit, 2 store miss, 3 store hit
  longint exp_fl = 0;
  longint exp_cl = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint span_lines(input longint a, input longint s);
    if (s == 0) return 1;
    return (((a + s - 1) >> OFF) - (a >> OFF)) + 1;
  endfunction

  function automatic longint line_addr(input longint a, input int i);
    if (i == 0) return a;
    return ((a >> OFF) + i) << OFF;
  endfunction

  task automatic check_stats(input string tag);
    chk(c_lm == exp_slot[0], {"R7 load miss ", tag}, c_lm, exp_slot[0]);
    chk(c_lh == exp_slot[1], {"R7 load hit ", tag}, c_lh, exp_slot[1]);
    chk(c_sm == exp_slot[2], {"R7 store miss ", tag}, c_sm, exp_slot[2]);
    chk(c_sh == exp_slot[3], {"R7 store hit ", tag}, c_sh, exp_slot[3]);
    chk(c_la == exp_slot[0] + exp_slot[1], {"R8 load acc ", tag}, c_la, exp_slot[0] + exp_slot[1]);
    chk(c_sa == exp_slot[2] + exp_slot[3], {"R8 store acc ", tag}, c_sa, exp_slot[2] + exp_slot[3]);
    chk(c_th == exp_slot[1] + exp_slot[3], {"R8 total hit ", tag}, c_th, exp_slot[1] + exp_slot[3]);
    chk(c_tm == exp_slot[0] + exp_slot[2], {"R8 total miss ", tag}, c_tm, exp_slot[0] + exp_slot[2]);
    chk(c_ta == exp_slot[0] + exp_slot[1] + exp_slot[2] + exp_slot[3], {"R8 total acc ", tag},
        c_ta, exp_slot[0] + exp_slot[1] + exp_slot[2] + exp_slot[3]);
    chk(c_fl == exp_fl, {"R9 flush count ", tag}, c_fl, exp_fl);
    chk(c_cl == exp_cl, {"R9 clear count ", tag}, c_cl, exp_cl);
  endtask

  task automatic run_req(input longint a, input longint s, input bit st,
                         input logic [7:0] asid, input logic [7:0] pat, input bit clr_end);
    longint n, nl, ea;
    bit exp_tr, exp_all;
    logic [MAX_LINES-1:0] exp_vec;
    int k, guard;
    n      = span_lines(a, s);
    nl     = (n > MAX_LINES) ? MAX_LINES : n;
    exp_tr = (n > MAX_LINES);
    exp_vec = '0;
    exp_all = 1'b1;
    for (int i = 0; i < nl; i++) begin
      ea = line_addr(a, i);
      exp_vec[i] = pat[ea[OFF+2:OFF]];
      exp_all &= pat[ea[OFF+2:OFF]];
    end
    @(negedge clk);
    hit_pat   = pat;
    req_valid = 1'b1;
    req_addr  = a[ADDR_W-1:0];
    req_size  = s[SIZE_W-1:0];
    req_store = st;
    req_asid  = asid;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    guard = 0;
    while (!done && guard < 40) begin
      if (lk_valid) begin
        ea = line_addr(a, k);
        chk(lk_addr == ea[ADDR_W-1:0], "R2 lookup address", lk_addr, ea[ADDR_W-1:0]);
        chk(lk_write == st, "R5 write flag", lk_write, st);
        chk(lk_asid == asid, "R5 identifier", lk_asid, asid);
        if (k == 0) chk(req_ready == 1'b0, "R6 busy ready", req_ready, 0);
        if (clr_end && k == nl - 1) cmd_stats_clr = 1'b1;
        k++;
      end
      @(negedge clk);
      cmd_stats_clr = 1'b0;
      guard++;
    end
    chk(done == 1'b1, "R6 done seen", done, 1);
    chk(req_ready == 1'b1, "R6 ready at done", req_ready, 1);
    chk(k == nl, "R3 lookup count", k, nl);
    chk(res_lines == nl[LCNT_W-1:0], "R3 res_lines", res_lines, nl);
    chk(res_hit_vec == exp_vec, "R4 hit vector", res_hit_vec, exp_vec);
    chk(res_all_hit == exp_all, "R4 all hit", res_all_hit, exp_all);
    chk(res_trunc == exp_tr, "R11 truncation", res_trunc, exp_tr);
    if (clr_end) begin
      for (int j = 0; j < 4; j++) exp_slot[j] = 0;
      exp_cl++;
    end
    exp_slot[{st, exp_all}]++;
    check_stats(clr_end ? "R10 collision" : "after request");
    @(negedge clk);
    chk(done == 1'b0, "R6 done pulse width", done, 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    cmd_flush = 1'b1;
    @(negedge clk);
    cmd_flush = 1'b0;
    exp_fl++;
    check_stats("R9 after flush");
  endtask

  task automatic do_clear();
    @(negedge clk);
    cmd_stats_clr = 1'b1;
    @(negedge clk);
    cmd_stats_clr = 1'b0;
    for (int j = 0; j < 4; j++) exp_slot[j] = 0;
    exp_cl++;
    check_stats("R9 after clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int j = 0; j < 4; j++) exp_slot[j] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(lk_valid == 1'b0, "R1 lookup idle", lk_valid, 0);
    check_stats("R1 reset");

    // Directed corners
    run_req(64'h1234, 0, 1'b0, 8'h11, 8'hFF, 1'b0);   // R3 zero size
    run_req(64'h1000, 64, 1'b0, 8'h12, 8'h00, 1'b0);  // R3 exact single line
    run_req(64'h103F, 2, 1'b1, 8'h13, 8'h01, 1'b0);   // R2 crossing, store partial hit
    run_req(64'h2000, 512, 1'b1, 8'h14, 8'hFF, 1'b0); // R11 exactly at cap
    run_req(64'h2000, 513, 1'b0, 8'h15, 8'hAA, 1'b0); // R11 one beyond cap
    run_req(64'h3010, 4000, 1'b1, 8'h16, 8'hFF, 1'b0);// R11 long, store hit
    do_flush();                                        // R9
    do_clear();                                        // R9
    run_req(64'h4020, 100, 1'b1, 8'h17, 8'hFF, 1'b1); // R10 collision
    run_req(64'h5000, 0, 1'b0, 8'h18, 8'h00, 1'b1);   // R10 single-line collision

    // Randomized mix
    for (int r = 0; r < 60; r++) begin
      longint a, s;
      a = longint'($urandom & 32'h7FFF_FFFF);
      s = longint'($urandom_range(0, 700));
      run_req(a, s, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom),
              ($urandom_range(0, 4) == 0));
      if ($urandom_range(0, 5) == 0) do_flush();
      if ($urandom_range(0, 9) == 0) do_clear();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule